// File: doc/BRIEF.md
# Listener Byte Acceptor

This block runs the receiving side of the three-wire byte handshake on an IEEE-488 bus for a single device. An upstream sequencer asks for a byte by pulsing `start_i`. The acceptor then signals ready and waits for the talker to mark the data valid. It captures the eight data lines, which are active-low, and returns the byte in true polarity. The attention and end flags are captured with the same byte, and a one-clock strobe marks the capture. It then completes the handshake, holds the bus not-ready, and waits for the sequencer to ask for another byte or to hand the bus back.

While the block is idle, a falling attention line pulls the not-ready-for-data line low through a purely combinational path. This meets the bus response limit without waiting for any clock. The controller can turn the path off. Data-valid, attention, end and interface-clear pass through synchronisers before the state machine uses them. Data-valid is also filtered so that a single-sample glitch cannot start a capture. Both handshake outputs are pull-low enables for wired-OR lines, and the block never drives either line high.

Top module: `hs_listener`

## Requirements
- R1: After reset the block is idle: `ndac_pull_o` is 0, `byte_vld_o` is 0, and `nrfd_pull_o` follows the fast path of R2.
- R2: While idle, `nrfd_pull_o` equals `atn_fast_en_i & ~atn_ni` combinationally, with no clock edge in the path. When the enable is 0, `nrfd_pull_o` is 0.
- R3: After `start_i` in idle or hold, the block enters a ready phase with `nrfd_pull_o`=0 and `ndac_pull_o`=1. It stays there until data-valid (`dav_ni`=0) is seen.
- R4: Once data-valid is seen, `nrfd_pull_o` goes to 1 and the byte is latched. `byte_vld_o` is then high for exactly one clock. During that clock `nrfd_pull_o`=1 and `ndac_pull_o`=0.
- R5: `byte_o` is the bitwise inverse of the `dio_ni` levels. `byte_atn_o` is 1 when `atn_ni` was low with the byte, and `byte_eoi_o` is 1 when `eoi_ni` was low with the byte.
- R6: After data-valid returns high (`dav_ni`=1), both pulls are 1 and stay 1 until `start_i` (back to ready) or `release_i` (back to idle).
- R7: Data-valid must keep the same synchronised level for two consecutive clock samples before it is acted on. A low pulse that lasts one clock causes no capture and leaves the block in ready.
- R8: An `ifc_ni` low level returns the block to idle within three clocks, with `ndac_pull_o`=0. `start_i` has no effect while `ifc_ni` is low.
- R9: Outside idle, `nrfd_pull_o` and `ndac_pull_o` are never both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dio_ni | input | 8 | Data lines, bus levels (active low) |
| dav_ni | input | 1 | Data valid, bus level (low = valid) |
| atn_ni | input | 1 | Attention, bus level (low = command) |
| eoi_ni | input | 1 | End flag, bus level (low = last byte) |
| ifc_ni | input | 1 | Interface clear, bus level (low = clear) |
| atn_fast_en_i | input | 1 | Enables the ATN-to-NRFD path while idle |
| start_i | input | 1 | Pulse: accept one byte |
| release_i | input | 1 | Pulse in hold: return to idle |
| nrfd_pull_o | output | 1 | 1 = pull not-ready-for-data low |
| ndac_pull_o | output | 1 | 1 = pull not-data-accepted low |
| byte_o | output | 8 | Captured byte, true polarity |
| byte_atn_o | output | 1 | Attention was asserted with the byte |
| byte_eoi_o | output | 1 | End flag was asserted with the byte |
| byte_vld_o | output | 1 | One-clock strobe on capture |

## Verification
Random bytes are sent with random attention and end flags, back to back, so that any inverted, swapped or stuck data bit or flag shows in `byte_o`. The walking-one and all-zero/all-one bytes separate single-bit faults from polarity faults. A one-clock data-valid glitch separates a real two-sample filter from one that passes a single sample. Interface-clear is raised in the ready phase and `start_i` is pulsed while it is held, which shows that clear overrides the state machine and that a start during clear is dropped. The fast path is tested between clock edges with its enable both on and off.

// File: rtl/hs_listener_pkg.sv
package hs_listener_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_LATCH = 3'd2,
    ST_DRAIN = 3'd3,
    ST_HOLD  = 3'd4
  } hs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hs_debounce.sv
module hs_debounce #(
  parameter int unsigned SAMPLES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(SAMPLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= RST_VAL;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      lvl_q <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
  import hs_listener_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      release_i,
  input  logic      dav_low_i,
  input  logic      ifc_act_i,
  output hs_state_e state_o,
  output logic      latch_o,
  output logic      nrfd_req_o,
  output logic      ndac_req_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_READY;
      ST_READY: if (dav_low_i) state_d = ST_LATCH;
      ST_LATCH: state_d = ST_DRAIN;
      ST_DRAIN: if (!dav_low_i) state_d = ST_HOLD;
      ST_HOLD: begin
        if (release_i)    state_d = ST_IDLE;
        else if (start_i) state_d = ST_READY;
      end
      default:  state_d = ST_IDLE;
    endcase
    if (ifc_act_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o    = state_q;
  assign latch_o    = (state_q == ST_LATCH) && !ifc_act_i;
  assign nrfd_req_o = (state_q == ST_LATCH) || (state_q == ST_DRAIN) || (state_q == ST_HOLD);
  assign ndac_req_o = (state_q == ST_READY) || (state_q == ST_LATCH) || (state_q == ST_HOLD);
endmodule

// File: rtl/hs_listener.sv
module hs_listener
  import hs_listener_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DB_SAMPLES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] dio_ni,
  input  logic              dav_ni,
  input  logic              atn_ni,
  input  logic              eoi_ni,
  input  logic              ifc_ni,
  input  logic              atn_fast_en_i,
  input  logic              start_i,
  input  logic              release_i,
  output logic              nrfd_pull_o,
  output logic              ndac_pull_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_atn_o,
  output logic              byte_eoi_o,
  output logic              byte_vld_o
);
  localparam int unsigned CTRL_W = 3;

  logic [DATA_W-1:0] dio_s;
  logic [CTRL_W-1:0] ctrl_s;
  logic              dav_s, dav_db;
  logic              atn_s, eoi_s, ifc_s;
  logic              dav_low, ifc_act;
  logic              latch, nrfd_req, ndac_req, idle;
  hs_state_e         state;

  logic [DATA_W-1:0] byte_q;
  logic              atn_q, eoi_q, vld_q;

  hs_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_dio_sync (
    .clk_i, .rst_ni, .d_i(dio_ni), .q_o(dio_s)
  );

  hs_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_ctrl_sync (
    .clk_i, .rst_ni, .d_i({atn_ni, eoi_ni, ifc_ni}), .q_o(ctrl_s)
  );

  hs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dav_sync (
    .clk_i, .rst_ni, .d_i(dav_ni), .q_o(dav_s)
  );

  hs_debounce #(.SAMPLES(DB_SAMPLES), .RST_VAL(1'b1)) u_dav_db (
    .clk_i, .rst_ni, .d_i(dav_s), .q_o(dav_db)
  );

  assign {atn_s, eoi_s, ifc_s} = ctrl_s;
  assign dav_low = !dav_db;
  assign ifc_act = !ifc_s;

  hs_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i, .release_i,
    .dav_low_i(dav_low), .ifc_act_i(ifc_act),
    .state_o(state), .latch_o(latch),
    .nrfd_req_o(nrfd_req), .ndac_req_o(ndac_req)
  );

  // bus lines are active low: store true polarity
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      atn_q  <= 1'b0;
      eoi_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= latch;
      if (latch) begin
        byte_q <= ~dio_s;
        atn_q  <= ~atn_s;
        eoi_q  <= ~eoi_s;
      end
    end
  end

  assign idle = (state == ST_IDLE);

  // fast path: raw ATN straight to NRFD while idle, no clock in between
  assign nrfd_pull_o = idle ? (atn_fast_en_i & ~atn_ni) : nrfd_req;
  assign ndac_pull_o = idle ? 1'b0 : ndac_req;

  assign byte_o     = byte_q;
  assign byte_atn_o = atn_q;
  assign byte_eoi_o = eoi_q;
  assign byte_vld_o = vld_q;
endmodule

// File: rtl/hs_listener_chk.sv
module hs_listener_chk
  import hs_listener_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      nrfd_pull_o,
  input logic      ndac_pull_o,
  input logic      byte_vld_o,
  input logic      atn_fast_en_i,
  input logic      ifc_act_i,
  input logic      dav_low_i,
  input hs_state_e state_i
);
  // R1
  idle_ndac_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !ndac_pull_o);

  // R2
  fast_path_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && !atn_fast_en_i) |-> !nrfd_pull_o);

  // R3
  ready_levels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_READY) |-> (!nrfd_pull_o && ndac_pull_o));

  // R4
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  // R4
  strobe_levels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> (nrfd_pull_o && !ndac_pull_o));

  // R6
  hold_levels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HOLD) |-> (nrfd_pull_o && ndac_pull_o));

  // R7
  no_early_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_READY && !dav_low_i) |=> (state_i != ST_LATCH));

  // R8
  clear_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifc_act_i |=> (state_i == ST_IDLE));

  // R9
  never_both_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE) |-> (nrfd_pull_o || ndac_pull_o));
endmodule

bind hs_listener hs_listener_chk u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .nrfd_pull_o(nrfd_pull_o),
  .ndac_pull_o(ndac_pull_o),
  .byte_vld_o(byte_vld_o),
  .atn_fast_en_i(atn_fast_en_i),
  .ifc_act_i(ifc_act),
  .dav_low_i(dav_low),
  .state_i(state)
);

// File: tb/hs_listener_bench.sv
module hs_listener_bench;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [7:0] dio_ni;
  logic       dav_ni, atn_ni, eoi_ni, ifc_ni;
  logic       atn_fast_en_i, start_i, release_i;
  logic       nrfd_pull_o, ndac_pull_o;
  logic [7:0] byte_o;
  logic       byte_atn_o, byte_eoi_o, byte_vld_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  hs_listener u_hs_listener (
    .clk_i(clk), .rst_ni, .dio_ni, .dav_ni, .atn_ni, .eoi_ni, .ifc_ni,
    .atn_fast_en_i, .start_i, .release_i,
    .nrfd_pull_o, .ndac_pull_o, .byte_o, .byte_atn_o, .byte_eoi_o, .byte_vld_o
  );

  function automatic logic [7:0] exp_byte(input logic [7:0] levels);
    return ~levels;
  endfunction

  function automatic logic exp_fast(input logic en, input logic atn_level);
    return en & ~atn_level;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // talker side of one byte, sequencer has already issued start
  task automatic send_byte(input logic [7:0] data, input logic atn, input logic eoi);
    int guard;
    dio_ni = ~data;
    atn_ni = ~atn;
    eoi_ni = ~eoi;
    guard = 0;
    while (nrfd_pull_o && guard < 50) begin @(negedge clk); guard++; end
    check(!nrfd_pull_o && ndac_pull_o, "R3", "ready levels nrfd/ndac",
          {nrfd_pull_o, ndac_pull_o}, 2'b01);
    dav_ni = 1'b0;
    guard = 0;
    while (!byte_vld_o && guard < 50) begin @(negedge clk); guard++; end
    check(byte_vld_o, "R4", "strobe seen", byte_vld_o, 1);
    check(byte_o == exp_byte(~data), "R5", "byte", byte_o, data);
    check(byte_atn_o == atn && byte_eoi_o == eoi, "R5", "atn/eoi flags",
          {byte_atn_o, byte_eoi_o}, {atn, eoi});
    check(nrfd_pull_o && !ndac_pull_o, "R4", "levels at strobe",
          {nrfd_pull_o, ndac_pull_o}, 2'b10);
    @(negedge clk);
    check(!byte_vld_o, "R4", "strobe one clock", byte_vld_o, 0);
    dav_ni = 1'b1;
    guard = 0;
    while (!ndac_pull_o && guard < 50) begin @(negedge clk); guard++; end
    check(nrfd_pull_o && ndac_pull_o, "R6", "hold levels",
          {nrfd_pull_o, ndac_pull_o}, 2'b11);
    repeat (3) @(negedge clk);
    check(nrfd_pull_o && ndac_pull_o, "R6", "hold persists",
          {nrfd_pull_o, ndac_pull_o}, 2'b11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic       a, e;
    void'($urandom(32'h5eed_0488));
    rst_ni = 1'b0;
    dio_ni = 8'hFF; dav_ni = 1'b1; atn_ni = 1'b1; eoi_ni = 1'b1; ifc_ni = 1'b1;
    atn_fast_en_i = 1'b1; start_i = 1'b0; release_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!ndac_pull_o && !byte_vld_o && !nrfd_pull_o, "R1", "reset outputs",
          {nrfd_pull_o, ndac_pull_o, byte_vld_o}, 3'b000);

    // R2: fast path between edges
    atn_ni = 1'b0; #1;
    check(nrfd_pull_o == exp_fast(1'b1, 1'b0), "R2", "fast path on", nrfd_pull_o, 1);
    atn_fast_en_i = 1'b0; #1;
    check(nrfd_pull_o == exp_fast(1'b0, 1'b0), "R2", "fast path off", nrfd_pull_o, 0);
    atn_fast_en_i = 1'b1; atn_ni = 1'b1; #1;
    check(nrfd_pull_o == exp_fast(1'b1, 1'b1), "R2", "atn high", nrfd_pull_o, 0);
    @(negedge clk);

    // directed bytes
    pulse_start(); send_byte(8'h24, 1'b1, 1'b0);
    pulse_start(); send_byte(8'h00, 1'b0, 1'b0);
    pulse_start(); send_byte(8'hFF, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      pulse_start(); send_byte(8'h01 << i, 1'b0, 1'b0);
    end

    // R7: one-clock glitch on data valid
    pulse_start();
    repeat (2) @(negedge clk);
    dio_ni = ~8'h5A;
    dav_ni = 1'b0; @(negedge clk); dav_ni = 1'b1;
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (byte_vld_o) seen = 1'b1;
      end
      check(!seen, "R7", "glitch strobe", seen, 0);
    end
    check(!nrfd_pull_o && ndac_pull_o, "R7", "still ready after glitch",
          {nrfd_pull_o, ndac_pull_o}, 2'b01);
    send_byte(8'h5A, 1'b0, 1'b0);

    // R6: release back to idle
    release_i = 1'b1; @(negedge clk); release_i = 1'b0;
    @(negedge clk);
    check(!ndac_pull_o && !nrfd_pull_o, "R6", "release to idle",
          {nrfd_pull_o, ndac_pull_o}, 2'b00);

    // random bytes
    for (int i = 0; i < 24; i++) begin
      d = 8'($urandom);
      a = 1'($urandom);
      e = 1'($urandom);
      pulse_start(); send_byte(d, a, e);
    end

    // R8: interface clear from ready
    pulse_start();
    @(negedge clk);
    ifc_ni = 1'b0; atn_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(!ndac_pull_o, "R8", "ndac released on clear", ndac_pull_o, 0);
    check(nrfd_pull_o == exp_fast(1'b1, 1'b0), "R8", "nrfd under atn", nrfd_pull_o, 1);
    pulse_start();
    repeat (3) @(negedge clk);
    check(!ndac_pull_o && nrfd_pull_o, "R8", "start ignored during clear",
          {nrfd_pull_o, ndac_pull_o}, 2'b10);
    atn_ni = 1'b1; ifc_ni = 1'b1;
    repeat (4) @(negedge clk);
    check(!ndac_pull_o && !nrfd_pull_o, "R9", "idle after clear",
          {nrfd_pull_o, ndac_pull_o}, 2'b00);
    pulse_start(); send_byte(8'h3F, 1'b1, 1'b0);
    summary();
  end
endmodule